// File: doc/BRIEF.md
# Set-Associative Data TLB Lookup

This unit translates data-side virtual addresses into physical addresses with a set-associative translation buffer. Each way keeps, per set, a match entry (valid bit, virtual tag, small age counter) and a translate entry (physical page number, cache-inhibit flag and four access-permission bits). A request carries a 32-bit virtual address together with flags for write access, supervisor privilege and a side-effect-free probe. One cycle after it is accepted, the unit returns the physical address, a cache-inhibit indication, a hit flag, and single-cycle page-fault and miss pulses.

Entries are loaded through a plain write port that addresses one way, one set and either the match or the translate entry. When translation is switched off, or the buffer is marked absent, addresses pass through unchanged and cache-inhibit is derived from the top address bit. Because refill is done elsewhere, the unit also reports which way in the indexed set has the lowest age. That is the way a refill would replace.

Top module: `dtlb_xlate`

## Requirements
- R1: With 8 KB pages and 64 sets, the set index is vaddr[18:13] and the tag is vaddr[31:19]. A way hits only when its valid bit is set and its stored tag equals that tag.
- R2: When more than one way of the set hits, the way with the highest number supplies the translation.
- R3: On a hit, a supervisor write needs the swe bit, a supervisor read sre, a user write uwe and a user read ure. A missing permission gives a one-cycle rsp_fault with rsp_hit=1 and rsp_paddr=0.
- R4: A non-probe hit, including one that faults, decrements every nonzero age counter of the indexed set by one and then sets the hit way's counter to 3. rsp_victim reports the lowest-numbered way with the smallest age before the update.
- R5: On a permitted hit, rsp_paddr is {ppn, vaddr[12:0]} and rsp_ci equals the entry's ci bit.
- R6: When xlat_en=0 or tlb_present=0, a non-probe request returns rsp_paddr=vaddr, rsp_hit=0, rsp_victim=0 and rsp_ci=vaddr[31].
- R7: A non-probe miss gives a one-cycle rsp_miss with rsp_paddr=0 and rsp_hit=0, and changes no entry. rsp_fault and rsp_miss are never high together.
- R8: A probe raises neither pulse and changes no age counter. A probe miss or a probe permission failure returns rsp_paddr=0 and keeps rsp_ci. A probe with translation off keeps rsp_ci.
- R9: req_ready is always 1. rsp_valid is high exactly in the cycle after an accepted request, and rsp_fault and rsp_miss only go high together with rsp_valid.
- R10: Word layout for writes. wr_sel=0 writes the match entry: bit0 valid, bits[2:1] age, bits[31:19] tag. wr_sel=1 writes the translate entry: bit0 ci, bit1 ure, bit2 uwe, bit3 sre, bit4 swe, bits[31:13] ppn. A write in the same cycle as a lookup of that set takes effect after the lookup, and wins over the age update.
- R11: After reset all entries are invalid with age 0, and rsp_valid, rsp_fault, rsp_miss, rsp_hit and rsp_paddr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlat_en | input | 1 | Translation enable |
| tlb_present | input | 1 | Buffer present; 0 forces pass-through |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Request accepted (always 1) |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_super | input | 1 | 1 = supervisor privilege |
| req_probe | input | 1 | 1 = side-effect-free probe |
| rsp_valid | output | 1 | Response valid |
| rsp_paddr | output | 32 | Physical address, 0 on failure |
| rsp_ci | output | 1 | Cache-inhibit |
| rsp_hit | output | 1 | A way matched |
| rsp_fault | output | 1 | Page-fault pulse |
| rsp_miss | output | 1 | Miss pulse |
| rsp_victim | output | 1 | Way with the lowest age in the indexed set |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 1 | Way to write |
| wr_set | input | 6 | Set to write |
| wr_sel | input | 1 | 0 = match entry, 1 = translate entry |
| wr_data | input | 32 | Entry word |

## Verification
The two functions that can meet in one cycle are a lookup and an entry write to the same set. The lookup also updates that set's age counters, so both act on the same storage at the same edge. The bench provokes this with directed invalidations of the very way being looked up, and with a random phase that issues writes and lookups together on two shared sets. A behavioural reference model judges every response: the lookup must see the old contents, the next lookup must see the write, and rsp_victim must reflect the age counter as rewritten by the write.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned ATTR_W = 5;
  localparam logic        SEL_MATCH = 1'b0;
  localparam logic        SEL_XLATE = 1'b1;

  // bit 0 ci, 1 ure, 2 uwe, 3 sre, 4 swe
  typedef struct packed {
    logic swe;
    logic sre;
    logic uwe;
    logic ure;
    logic ci;
  } attr_t;

  function automatic logic perm_ok(attr_t a, logic is_wr, logic is_sup);
    logic ok;
    case ({is_sup, is_wr})
      2'b11:   ok = a.swe;
      2'b10:   ok = a.sre;
      2'b01:   ok = a.uwe;
      default: ok = a.ure;
    endcase
    return ok;
  endfunction
endpackage

// File: rtl/dtlb_way.sv
module dtlb_way
  import dtlb_pkg::*;
#(
  parameter int unsigned SET_BITS = 6,
  parameter int unsigned TAG_W    = 13,
  parameter int unsigned PPN_W    = 19,
  parameter int unsigned LRU_W    = 2,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] rd_set,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [LRU_W-1:0]    rd_lru,
  output logic [PPN_W-1:0]    rd_ppn,
  output attr_t               rd_attr,
  input  logic                lru_we,
  input  logic [LRU_W-1:0]    lru_val,
  input  logic                wr_en,
  input  logic                wr_sel,
  input  logic [SET_BITS-1:0] wr_set,
  input  logic [DATA_W-1:0]   wr_data
);
  localparam int unsigned SETS = 1 << SET_BITS;

  logic [SETS-1:0]  valid_q;
  logic [LRU_W-1:0] lru_q  [SETS];
  logic [TAG_W-1:0] tag_q  [SETS];
  logic [PPN_W-1:0] ppn_q  [SETS];
  attr_t            attr_q [SETS];

  logic wr_match, wr_xlate;
  logic wr_unused;

  assign wr_match  = wr_en && (wr_sel == SEL_MATCH);
  assign wr_xlate  = wr_en && (wr_sel == SEL_XLATE);
  assign wr_unused = &{1'b0, wr_data};

  assign rd_valid = valid_q[rd_set];
  assign rd_tag   = tag_q[rd_set];
  assign rd_lru   = lru_q[rd_set];
  assign rd_ppn   = ppn_q[rd_set];
  assign rd_attr  = attr_q[rd_set];

  // control state: valid and age are reset, entry write lands after the age update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int s = 0; s < int'(SETS); s++) lru_q[s] <= '0;
    end else begin
      if (lru_we)
        lru_q[rd_set] <= lru_val;
      if (wr_match) begin
        valid_q[wr_set] <= wr_data[0];
        lru_q[wr_set]   <= wr_data[LRU_W:1];
      end
    end
  end

  // payload storage, no reset
  always_ff @(posedge clk) begin
    if (wr_match)
      tag_q[wr_set] <= wr_data[DATA_W-1 -: TAG_W];
    if (wr_xlate) begin
      ppn_q[wr_set]  <= wr_data[DATA_W-1 -: PPN_W];
      attr_q[wr_set] <= attr_t'(wr_data[ATTR_W-1:0]);
    end
  end
endmodule

// File: rtl/dtlb_lookup.sv
module dtlb_lookup #(
  parameter int unsigned WAYS  = 2,
  parameter int unsigned TAG_W = 13,
  parameter int unsigned LRU_W = 2,
  parameter int unsigned WAY_W = 1
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [WAYS-1:0][LRU_W-1:0] way_lru,
  input  logic [TAG_W-1:0]           req_tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic [WAY_W-1:0]           victim_way,
  output logic [WAYS-1:0][LRU_W-1:0] lru_next
);
  localparam logic [LRU_W-1:0] LRU_MAX = {LRU_W{1'b1}};

  logic [LRU_W-1:0] min_lru;

  // ascending scan: the last matching way (highest number) wins
  always_comb begin
    hit     = 1'b0;
    hit_way = '0;
    for (int w = 0; w < int'(WAYS); w++) begin
      if (way_valid[w] && (way_tag[w] == req_tag)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
    end
  end

  // strict compare keeps the lowest-numbered way among equal ages
  always_comb begin
    victim_way = '0;
    min_lru    = way_lru[0];
    for (int w = 1; w < int'(WAYS); w++) begin
      if (way_lru[w] < min_lru) begin
        min_lru    = way_lru[w];
        victim_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    for (int w = 0; w < int'(WAYS); w++) begin
      if (WAY_W'(w) == hit_way)
        lru_next[w] = LRU_MAX;
      else if (way_lru[w] != '0)
        lru_next[w] = way_lru[w] - 1'b1;
      else
        lru_next[w] = '0;
    end
  end
endmodule

// File: rtl/dtlb_xlate.sv
module dtlb_xlate
  import dtlb_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned SET_BITS  = 6,
  parameter int unsigned WAYS      = 2,
  parameter int unsigned LRU_W     = 2,
  localparam int unsigned WAY_W    = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 xlat_en,
  input  logic                 tlb_present,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_W-1:0]      req_vaddr,
  input  logic                 req_write,
  input  logic                 req_super,
  input  logic                 req_probe,
  output logic                 rsp_valid,
  output logic [VA_W-1:0]      rsp_paddr,
  output logic                 rsp_ci,
  output logic                 rsp_hit,
  output logic                 rsp_fault,
  output logic                 rsp_miss,
  output logic [WAY_W-1:0]     rsp_victim,
  input  logic                 wr_en,
  input  logic [WAY_W-1:0]     wr_way,
  input  logic [SET_BITS-1:0]  wr_set,
  input  logic                 wr_sel,
  input  logic [VA_W-1:0]      wr_data
);
  localparam int unsigned TAG_W = VA_W - PAGE_BITS - SET_BITS;
  localparam int unsigned PPN_W = VA_W - PAGE_BITS;

  logic                       accept, xl_on;
  logic [SET_BITS-1:0]        set_idx;
  logic [TAG_W-1:0]           req_tag;
  logic [WAYS-1:0]            way_valid;
  logic [WAYS-1:0][TAG_W-1:0] way_tag;
  logic [WAYS-1:0][LRU_W-1:0] way_lru;
  logic [WAYS-1:0][LRU_W-1:0] lru_next;
  logic [PPN_W-1:0]           way_ppn  [WAYS];
  attr_t                      way_attr [WAYS];
  logic                       hit;
  logic [WAY_W-1:0]           hit_way, victim_way;
  attr_t                      sel_attr;
  logic [PPN_W-1:0]           sel_ppn;
  logic                       allowed, lru_upd;

  logic                       valid_q, fault_q, miss_q, hit_q, ci_q;
  logic [VA_W-1:0]            paddr_q;
  logic [WAY_W-1:0]           victim_q;
  logic                       nxt_valid, nxt_fault, nxt_miss, nxt_hit, nxt_ci;
  logic [VA_W-1:0]            nxt_paddr;
  logic [WAY_W-1:0]           nxt_victim;

  assign req_ready = 1'b1;
  assign accept    = req_valid && req_ready;
  assign xl_on     = xlat_en && tlb_present;
  assign set_idx   = req_vaddr[PAGE_BITS +: SET_BITS];
  assign req_tag   = req_vaddr[VA_W-1 -: TAG_W];

  for (genvar w = 0; w < int'(WAYS); w++) begin : g_way
    dtlb_way #(
      .SET_BITS (SET_BITS),
      .TAG_W    (TAG_W),
      .PPN_W    (PPN_W),
      .LRU_W    (LRU_W),
      .DATA_W   (VA_W)
    ) u_way (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (set_idx),
      .rd_valid (way_valid[w]),
      .rd_tag   (way_tag[w]),
      .rd_lru   (way_lru[w]),
      .rd_ppn   (way_ppn[w]),
      .rd_attr  (way_attr[w]),
      .lru_we   (lru_upd),
      .lru_val  (lru_next[w]),
      .wr_en    (wr_en && (wr_way == WAY_W'(w))),
      .wr_sel   (wr_sel),
      .wr_set   (wr_set),
      .wr_data  (wr_data)
    );
  end

  dtlb_lookup #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .LRU_W (LRU_W),
    .WAY_W (WAY_W)
  ) u_lookup (
    .way_valid  (way_valid),
    .way_tag    (way_tag),
    .way_lru    (way_lru),
    .req_tag    (req_tag),
    .hit        (hit),
    .hit_way    (hit_way),
    .victim_way (victim_way),
    .lru_next   (lru_next)
  );

  assign sel_attr = way_attr[hit_way];
  assign sel_ppn  = way_ppn[hit_way];
  assign allowed  = perm_ok(sel_attr, req_write, req_super);
  assign lru_upd  = accept && xl_on && hit && !req_probe;

  // next-state
  always_comb begin
    nxt_valid  = accept;
    nxt_fault  = 1'b0;
    nxt_miss   = 1'b0;
    nxt_hit    = hit_q;
    nxt_ci     = ci_q;
    nxt_paddr  = paddr_q;
    nxt_victim = victim_q;
    if (accept) begin
      if (!xl_on) begin
        nxt_paddr  = req_vaddr;
        nxt_hit    = 1'b0;
        nxt_victim = '0;
        if (!req_probe) nxt_ci = req_vaddr[VA_W-1];
      end else begin
        nxt_victim = victim_way;
        nxt_hit    = hit;
        if (hit) begin
          if (allowed) begin
            nxt_paddr = {sel_ppn, req_vaddr[PAGE_BITS-1:0]};
            nxt_ci    = sel_attr.ci;
          end else begin
            nxt_paddr = '0;
            nxt_fault = !req_probe;
            if (!req_probe) nxt_ci = sel_attr.ci;
          end
        end else begin
          nxt_paddr = '0;
          nxt_miss  = !req_probe;
        end
      end
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      fault_q  <= 1'b0;
      miss_q   <= 1'b0;
      hit_q    <= 1'b0;
      ci_q     <= 1'b0;
      paddr_q  <= '0;
      victim_q <= '0;
    end else begin
      valid_q <= nxt_valid;
      fault_q <= nxt_fault;
      miss_q  <= nxt_miss;
      if (accept) begin
        hit_q    <= nxt_hit;
        ci_q     <= nxt_ci;
        paddr_q  <= nxt_paddr;
        victim_q <= nxt_victim;
      end
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_fault  = fault_q;
  assign rsp_miss   = miss_q;
  assign rsp_hit    = hit_q;
  assign rsp_ci     = ci_q;
  assign rsp_paddr  = paddr_q;
  assign rsp_victim = victim_q;
endmodule

// File: rtl/dtlb_xlate_chk.sv
module dtlb_xlate_chk
  import dtlb_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 13
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xlat_en,
  input logic            tlb_present,
  input logic            req_valid,
  input logic            req_ready,
  input logic [VA_W-1:0] req_vaddr,
  input logic            req_probe,
  input logic            rsp_valid,
  input logic [VA_W-1:0] rsp_paddr,
  input logic            rsp_ci,
  input logic            rsp_hit,
  input logic            rsp_fault,
  input logic            rsp_miss
);
  logic acc, on;
  assign acc = req_valid && req_ready;
  assign on  = xlat_en && tlb_present;

  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);
  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !rsp_valid);
  p_pulse_with_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_fault || rsp_miss) |-> rsp_valid);
  p_miss_fault_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_fault && rsp_miss));
  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_paddr == '0) && !rsp_hit);
  p_fault_is_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_hit && (rsp_paddr == '0));
  p_probe_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_probe) |=> !rsp_fault && !rsp_miss);
  p_probe_ci_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_probe && !on) |=> $stable(rsp_ci));
  p_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !on && !req_probe) |=>
      (rsp_paddr == $past(req_vaddr)) && (rsp_ci == $past(req_vaddr[VA_W-1])) && !rsp_hit);
  p_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && on) |=>
      (rsp_paddr == '0) || (rsp_paddr[PAGE_BITS-1:0] == $past(req_vaddr[PAGE_BITS-1:0])));
endmodule

bind dtlb_xlate dtlb_xlate_chk #(.PAGE_BITS(PAGE_BITS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .xlat_en     (xlat_en),
  .tlb_present (tlb_present),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_vaddr   (req_vaddr),
  .req_probe   (req_probe),
  .rsp_valid   (rsp_valid),
  .rsp_paddr   (rsp_paddr),
  .rsp_ci      (rsp_ci),
  .rsp_hit     (rsp_hit),
  .rsp_fault   (rsp_fault),
  .rsp_miss    (rsp_miss)
);

// File: tb/sim_dtlb_xlate.sv
module sim_dtlb_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlat_en = 1'b0, tlb_present = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_super = 1'b0, req_probe = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        rsp_valid, rsp_ci, rsp_hit, rsp_fault, rsp_miss;
  logic [31:0] rsp_paddr;
  logic [0:0]  rsp_victim;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [0:0]  wr_way = '0;
  logic [5:0]  wr_set = '0;
  logic [31:0] wr_data = '0;

  dtlb_xlate u0 (
    .clk(clk), .rst_n(rst_n), .xlat_en(xlat_en), .tlb_present(tlb_present),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .req_super(req_super), .req_probe(req_probe),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_ci(rsp_ci), .rsp_hit(rsp_hit),
    .rsp_fault(rsp_fault), .rsp_miss(rsp_miss), .rsp_victim(rsp_victim),
    .wr_en(wr_en), .wr_way(wr_way), .wr_set(wr_set), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0, cycles = 0;
  bit done = 0;
  string cur_tag = "R11";

  // behavioural model state
  int m_v [2][NSETS], m_tag [2][NSETS], m_lru [2][NSETS], m_ppn [2][NSETS], m_attr [2][NSETS];
  int m_ci = 0;
  bit   e_valid = 0, e_fault = 0, e_miss = 0, e_hit = 0, e_ci = 0;
  int   e_paddr = 0, e_victim = 0;
  string e_tag = "R11";
  int s, t, way, a, minl;
  bit ok;

  function automatic int mk_match(int tg, int age, int v);
    return (tg << 19) | (age << 1) | v;
  endfunction
  function automatic int mk_xl(int ppn, int attr);
    return (ppn << 13) | attr;
  endfunction
  function automatic int mk_va(int tg, int st, int off);
    return (tg << 19) | (st << 13) | off;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < NSETS; k++) begin
          m_v[w][k] = 0; m_lru[w][k] = 0; m_tag[w][k] = 0; m_ppn[w][k] = 0; m_attr[w][k] = 0;
        end
      m_ci = 0; e_valid = 0; e_fault = 0; e_miss = 0;
    end else begin
      e_tag = cur_tag;
      e_valid = req_valid; e_fault = 0; e_miss = 0;
      if (req_valid) begin
        if (!(xlat_en && tlb_present)) begin
          e_paddr = req_vaddr; e_hit = 0; e_victim = 0;
          if (!req_probe) m_ci = req_vaddr[31];
        end else begin
          s = (req_vaddr >> 13) % NSETS;
          t = req_vaddr >> 19;
          way = -1;
          for (int w = 0; w < 2; w++) if (m_v[w][s] != 0 && m_tag[w][s] == t) way = w;
          minl = m_lru[0][s]; e_victim = 0;
          for (int w = 1; w < 2; w++) if (m_lru[w][s] < minl) begin minl = m_lru[w][s]; e_victim = w; end
          if (way >= 0) begin
            e_hit = 1;
            a = m_attr[way][s];
            if (req_super) ok = req_write ? a[4] : a[3];
            else           ok = req_write ? a[2] : a[1];
            if (ok) begin
              e_paddr = (m_ppn[way][s] << 13) | (req_vaddr & 32'h1fff);
              m_ci = a[0];
            end else begin
              e_paddr = 0;
              e_fault = !req_probe;
              if (!req_probe) m_ci = a[0];
            end
            if (!req_probe) begin
              for (int w = 0; w < 2; w++) if (m_lru[w][s] > 0) m_lru[w][s]--;
              m_lru[way][s] = 3;
            end
          end else begin
            e_hit = 0; e_paddr = 0; e_miss = !req_probe;
          end
        end
        e_ci = m_ci[0];
      end
      if (wr_en) begin
        if (wr_sel == 1'b0) begin
          m_v[wr_way][wr_set] = wr_data[0];
          m_lru[wr_way][wr_set] = wr_data[2:1];
          m_tag[wr_way][wr_set] = wr_data[31:19];
        end else begin
          m_attr[wr_way][wr_set] = wr_data[4:0];
          m_ppn[wr_way][wr_set] = wr_data[31:13];
        end
      end
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(e_tag, "rsp_valid (R9)", {31'b0, rsp_valid}, {31'b0, e_valid});
      chk(e_tag, "rsp_fault (R3)", {31'b0, rsp_fault}, {31'b0, e_fault});
      chk(e_tag, "rsp_miss (R7)", {31'b0, rsp_miss}, {31'b0, e_miss});
      chk("R9", "req_ready", {31'b0, req_ready}, 32'd1);
      if (e_valid) begin
        chk(e_tag, "rsp_paddr", rsp_paddr, e_paddr);
        chk(e_tag, "rsp_ci", {31'b0, rsp_ci}, {31'b0, e_ci});
        chk(e_tag, "rsp_hit", {31'b0, rsp_hit}, {31'b0, e_hit});
        chk(e_tag, "rsp_victim (R4)", {31'b0, rsp_victim}, e_victim);
      end
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      n_fail++;
      $display("FAIL R9 watchdog expired act=%0d exp<150000", cycles);
      summary();
      $finish;
    end
  end

  // one cycle of stimulus, entered and left at a falling edge
  task automatic step(bit rv, int va, bit wr, bit sup, bit prb,
                      bit we, int wy, int st, bit sel, int d, string tag);
    req_valid = rv; req_vaddr = va; req_write = wr; req_super = sup; req_probe = prb;
    wr_en = we; wr_way = wy[0:0]; wr_set = st[5:0]; wr_sel = sel; wr_data = d;
    cur_tag = tag;
    @(negedge clk);
    req_valid = 0; wr_en = 0;
  endtask
  task automatic lk(int va, bit wr, bit sup, bit prb, string tag);
    step(1, va, wr, sup, prb, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic we(int wy, int st, bit sel, int d);
    step(0, 0, 0, 0, 0, 1, wy, st, sel, d, "R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R11: reset state
    chk("R11", "rsp_valid", {31'b0, rsp_valid}, 0);
    chk("R11", "rsp_fault", {31'b0, rsp_fault}, 0);
    chk("R11", "rsp_miss", {31'b0, rsp_miss}, 0);
    chk("R11", "rsp_hit", {31'b0, rsp_hit}, 0);
    chk("R11", "rsp_paddr", rsp_paddr, 0);

    // R6: pass-through
    lk(32'h8000_1234, 0, 0, 0, "R6");
    lk(32'h0000_4321, 1, 1, 0, "R6");
    xlat_en = 1; tlb_present = 0;
    lk(32'h9000_0010, 0, 0, 0, "R6");
    tlb_present = 1;

    // R11/R7: empty buffer misses
    lk(mk_va(1, 5, 16), 0, 0, 0, "R11");
    lk(mk_va(7, 63, 0), 1, 1, 0, "R7");

    // R1/R5: basic translation
    we(0, 5, 0, mk_match(1, 0, 1));
    we(0, 5, 1, mk_xl(32'h12345, 5'h1f));
    lk(mk_va(1, 5, 32'h10), 0, 0, 0, "R1");
    lk(mk_va(1, 5, 32'h1abc), 1, 1, 0, "R5");
    lk(mk_va(2, 5, 32'h4), 0, 0, 0, "R7");
    lk(mk_va(1, 6, 32'h4), 0, 0, 0, "R1");

    // R3: permission by privilege (only sre set)
    we(0, 7, 0, mk_match(3, 0, 1));
    we(0, 7, 1, mk_xl(32'h00777, 5'h08));
    lk(mk_va(3, 7, 1), 0, 0, 0, "R3");
    lk(mk_va(3, 7, 2), 1, 1, 0, "R3");
    lk(mk_va(3, 7, 3), 0, 1, 0, "R3");
    lk(mk_va(3, 7, 4), 1, 0, 0, "R3");

    // R2: duplicate tags, the higher way wins
    we(1, 5, 0, mk_match(1, 0, 1));
    we(1, 5, 1, mk_xl(32'h00abc, 5'h1e));
    lk(mk_va(1, 5, 32'h55), 0, 0, 0, "R2");

    // R4: age counters and victim choice
    we(0, 9, 0, mk_match(4, 0, 1));
    we(1, 9, 0, mk_match(5, 0, 1));
    we(0, 9, 1, mk_xl(1, 5'h1f));
    we(1, 9, 1, mk_xl(2, 5'h1f));
    lk(mk_va(4, 9, 0), 0, 0, 0, "R4");
    lk(mk_va(6, 9, 0), 0, 0, 0, "R4");
    lk(mk_va(5, 9, 0), 0, 0, 0, "R4");
    lk(mk_va(6, 9, 0), 0, 0, 0, "R4");

    // R8: probes leave no trace
    lk(mk_va(4, 9, 8), 0, 0, 1, "R8");
    lk(mk_va(6, 9, 0), 0, 0, 0, "R8");
    lk(mk_va(6, 9, 0), 0, 0, 1, "R8");
    lk(mk_va(3, 7, 9), 0, 0, 1, "R8");
    xlat_en = 0;
    lk(32'h0000_0100, 0, 0, 0, "R8");
    lk(32'h8000_0100, 0, 0, 1, "R8");
    xlat_en = 1;

    // R10: same-cycle write to the looked-up set
    step(1, mk_va(1, 5, 7), 0, 0, 0, 1, 1, 5, 0, mk_match(1, 0, 0), "R10");
    lk(mk_va(1, 5, 7), 0, 0, 0, "R10");
    step(1, mk_va(1, 5, 9), 0, 0, 0, 1, 0, 5, 0, mk_match(1, 0, 0), "R10");
    lk(mk_va(1, 5, 9), 0, 0, 0, "R10");
    step(1, mk_va(4, 9, 0), 0, 0, 0, 1, 1, 9, 0, mk_match(5, 0, 1), "R10");
    lk(mk_va(8, 9, 0), 0, 0, 0, "R10");

    // R1/R9: random mix of lookups and writes on two shared sets
    for (int i = 0; i < 400; i++) begin
      automatic bit rv  = $urandom_range(0, 1) == 1;
      automatic bit wev = $urandom_range(0, 2) == 0;
      automatic bit sel = $urandom_range(0, 1) == 1;
      automatic int st  = 3 + $urandom_range(0, 1);
      automatic int d   = sel ? mk_xl($urandom_range(0, 32'h7ffff), $urandom_range(0, 31))
                              : mk_match($urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3) != 0);
      automatic int va  = mk_va($urandom_range(0, 3), 3 + $urandom_range(0, 1), $urandom_range(0, 8191));
      step(rv, va, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, $urandom_range(0, 3) == 0,
           wev, $urandom_range(0, 1), st, sel, d, "R1");
    end

    repeat (3) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule